// File: doc/BRIEF.md
# Serial Status Flag Readout

This block lets a host controller read a vector of status and error flags through a single active-low output pin, with no clock of its own on the host side. The host steps through the flags by toggling its enable pin. The first toggle takes a snapshot of all flag inputs and shows bit 0. Each later toggle shows the next bit, and the pointer wraps from the last bit back to bit 0. The host reads each bit as the inverse of the error output level.

When the enable pin stops changing for a programmable number of clock cycles, the readout ends. The block then gives the mode controller a one-cycle pulse, so that mode handling goes back to the levels of the host pins. Outside a readout, the error output shows a summary. In low-power modes this is the wake indication; otherwise it is the general error indication. The flag sources, the summary sources and the mode come from outside the block as plain inputs. The enable input is expected to be synchronized to `clk` already.

Top module: `flagReadout`

## Requirements
- R1: After reset no readout is active, `resumePinMode` is low, and `errN` shows the idle summary.
- R2: The first transition of `enPin` while idle, in either direction, starts a readout. That clock edge stores a snapshot of `flagsIn`, and from the next cycle `errN` equals the inverse of snapshot bit 0.
- R3: Each further `enPin` transition during a readout advances the displayed bit by one position, so `errN` equals the inverse of snapshot bit i.
- R4: After bit NFLAGS-1 has been shown, the next transition shows bit 0 again.
- R5: Changes on `flagsIn` after the snapshot do not affect the bits shown during that readout.
- R6: If no `enPin` transition occurs for TIMEOUT_CYCLES consecutive clock edges after the last one, `readoutActive` falls and `resumePinMode` is high for exactly one cycle.
- R7: A transition that comes before the timeout expires restarts the idle count. The readout stays active.
- R8: While idle, `errN` is the inverse of `wakeFlag` when `lowPowerMode` is 1, and the inverse of `errorFlag` when `lowPowerMode` is 0.
- R9: `errN` shows the newly selected bit in the cycle that follows the clock edge sampling the transition. The level of `enPin` before the first edge after reset is taken as 0.
- R10: A readout that starts after a timeout begins at bit 0 with a fresh snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enPin | input | 1 | Host enable level; each transition steps the readout |
| flagsIn | input | NFLAGS | Live status and error flags |
| errorFlag | input | 1 | Summary error indication for normal modes |
| wakeFlag | input | 1 | Wake indication for low-power modes |
| lowPowerMode | input | 1 | 1 selects the wake summary while idle |
| errN | output | 1 | Active-low serial flag / summary output |
| readoutActive | output | 1 | High during a readout |
| resumePinMode | output | 1 | One-cycle pulse when a readout times out |

## Verification
A pointer that slips by one position shows at the very next enable transition: `errN` carries the wrong snapshot bit. A wrong wrap shows on the transition after the last bit. If the snapshot is not held, the output follows the live flags, which the bench inverts right after capture. A timeout counter that is off by one moves the fall of `readoutActive` and the resume pulse by a cycle. The bench samples both at the exact expected edge, so the error appears within TIMEOUT_CYCLES+1 cycles.

// File: rtl/flagReadPkg.sv
package flagReadPkg;
  typedef struct packed {
    logic capture;
    logic advance;
    logic finish;
  } ctrlStrobes_t;
endpackage

// File: rtl/flagReadCtrl.sv
module flagReadCtrl
  import flagReadPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enPin,
  output ctrlStrobes_t strobes,
  output logic         active,
  output logic         resumePulse
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_IDLE = CNT_W'(TIMEOUT_CYCLES - 1);

  logic             enPrev;
  logic             enEdge;
  logic             timeoutHit;
  logic [CNT_W-1:0] idleCnt;

  assign enEdge     = enPin ^ enPrev;
  assign timeoutHit = active && !enEdge && (idleCnt == LAST_IDLE);

  always_comb begin
    strobes.capture = enEdge && !active;
    strobes.advance = enEdge && active;
    strobes.finish  = timeoutHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev      <= 1'b0;
      active      <= 1'b0;
      idleCnt     <= '0;
      resumePulse <= 1'b0;
    end else begin
      enPrev      <= enPin;
      resumePulse <= timeoutHit;
      if (enEdge) begin
        active  <= 1'b1;
        idleCnt <= '0;
      end else if (timeoutHit) begin
        active  <= 1'b0;
        idleCnt <= '0;
      end else if (active) begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flagReadData.sv
module flagReadData
  import flagReadPkg::*;
#(
  parameter int NFLAGS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              active,
  input  logic [NFLAGS-1:0] flagsIn,
  input  logic              errorFlag,
  input  logic              wakeFlag,
  input  logic              lowPowerMode,
  output logic              errN
);
  localparam int PTR_W = (NFLAGS > 1) ? $clog2(NFLAGS) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NFLAGS - 1);

  logic [NFLAGS-1:0] snapshot;
  logic [PTR_W-1:0]  bitPtr;
  logic              summary;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapshot <= '0;
      bitPtr   <= '0;
    end else if (strobes.capture) begin
      snapshot <= flagsIn;
      bitPtr   <= '0;
    end else if (strobes.advance) begin
      bitPtr <= (bitPtr == LAST_PTR) ? '0 : bitPtr + 1'b1;
    end
  end

  assign summary = lowPowerMode ? wakeFlag : errorFlag;
  assign errN    = active ? ~snapshot[bitPtr] : ~summary;
endmodule

// File: rtl/flagReadout.sv
module flagReadout
  import flagReadPkg::*;
#(
  parameter int NFLAGS         = 16,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enPin,
  input  logic [NFLAGS-1:0] flagsIn,
  input  logic              errorFlag,
  input  logic              wakeFlag,
  input  logic              lowPowerMode,
  output logic              errN,
  output logic              readoutActive,
  output logic              resumePinMode
);
  ctrlStrobes_t strobes;
  logic         active;

  flagReadCtrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .enPin(enPin),
    .strobes(strobes), .active(active), .resumePulse(resumePinMode)
  );

  flagReadData #(.NFLAGS(NFLAGS)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .active(active),
    .flagsIn(flagsIn), .errorFlag(errorFlag), .wakeFlag(wakeFlag),
    .lowPowerMode(lowPowerMode), .errN(errN)
  );

  assign readoutActive = active;
endmodule

// File: rtl/flagReadChk.sv
module flagReadChk #(
  parameter int NFLAGS = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [NFLAGS-1:0] flagsIn,
  input logic              errorFlag,
  input logic              wakeFlag,
  input logic              lowPowerMode,
  input logic              errN,
  input logic              readoutActive,
  input logic              resumePinMode
);
  // R8: idle summary selection seen at the output
  p_idle_summary_r8: assert property (@(posedge clk) disable iff (!rstN)
    !readoutActive |-> errN == !(lowPowerMode ? wakeFlag : errorFlag));

  // R6: the resume pulse follows the end of an active readout
  p_resume_after_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    resumePinMode |-> (!readoutActive && $past(readoutActive)));

  // R6: the resume pulse lasts a single cycle
  p_resume_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    resumePinMode |=> !resumePinMode);

  // R2: the first bit shown is flag 0 as sampled at the start edge
  p_first_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readoutActive) |-> errN == !$past(flagsIn[0]));
endmodule

bind flagReadout flagReadChk #(.NFLAGS(NFLAGS)) u_chk (
  .clk(clk), .rstN(rstN), .flagsIn(flagsIn), .errorFlag(errorFlag),
  .wakeFlag(wakeFlag), .lowPowerMode(lowPowerMode), .errN(errN),
  .readoutActive(readoutActive), .resumePinMode(resumePinMode)
);

// File: tb/sim_flagReadout.sv
`timescale 1ns/1ps
module sim_flagReadout;
  localparam int NF = 16;
  localparam int TO = 8;
  localparam logic [NF-1:0] PATTERNS [4] = '{16'hA5C3, 16'h0001, 16'h8000, 16'h3CF0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enPin = 1'b0;
  logic [NF-1:0] flagsIn = '0;
  logic errorFlag = 1'b0, wakeFlag = 1'b0, lowPowerMode = 1'b0;
  logic errN, readoutActive, resumePinMode;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flagReadout #(.NFLAGS(NF), .TIMEOUT_CYCLES(TO)) u0 (
    .clk(clk), .rstN(rstN), .enPin(enPin), .flagsIn(flagsIn),
    .errorFlag(errorFlag), .wakeFlag(wakeFlag), .lowPowerMode(lowPowerMode),
    .errN(errN), .readoutActive(readoutActive), .resumePinMode(resumePinMode)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic toggleEn();
    @(negedge clk) enPin = ~enPin;
    @(posedge clk) #1;
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    errorFlag = 1'b1;
    idleCycles(3);
    // R1: reset state
    check("R1 active", readoutActive, 0);
    check("R1 resume", resumePinMode, 0);
    check("R1 errN", errN, 0);
    @(negedge clk) rstN = 1'b1;
    idleCycles(2);
    check("R1 after release", readoutActive, 0);

    // Table walk: each pattern read fully, wrapped, timed out
    for (int p = 0; p < 4; p++) begin
      logic [NF-1:0] pat;
      pat = PATTERNS[p];
      @(negedge clk) flagsIn = pat;
      toggleEn();
      check("R2 start", readoutActive, 1);
      check("R2 R9 R10 bit0", errN, int'(!pat[0]));
      @(negedge clk) flagsIn = ~pat;   // R5: live flags change after snapshot
      for (int b = 1; b < NF; b++) begin
        toggleEn();
        check("R3 R5 bit", errN, int'(!pat[b]));
      end
      toggleEn();
      check("R4 wrap", errN, int'(!pat[0]));
      idleCycles(TO - 1);
      check("R6 still active", readoutActive, 1);
      idleCycles(1);
      check("R6 ended", readoutActive, 0);
      check("R6 pulse", resumePinMode, 1);
      idleCycles(1);
      check("R6 pulse single", resumePinMode, 0);
    end

    // R7: transitions just inside the timeout keep the readout alive
    @(negedge clk) flagsIn = 16'h0006;
    toggleEn();
    idleCycles(TO - 2);
    toggleEn();
    check("R7 alive", readoutActive, 1);
    check("R7 bit1", errN, 0);
    idleCycles(TO - 2);
    toggleEn();
    check("R7 alive again", readoutActive, 1);
    check("R7 bit2", errN, 0);
    idleCycles(TO);
    check("R7 ends", readoutActive, 0);

    // R8: idle summary selection
    @(negedge clk) begin lowPowerMode = 1'b0; errorFlag = 1'b0; wakeFlag = 1'b1; end
    #1 check("R8 normal no error", errN, 1);
    @(negedge clk) errorFlag = 1'b1;
    #1 check("R8 normal error", errN, 0);
    @(negedge clk) begin lowPowerMode = 1'b1; wakeFlag = 1'b0; end
    #1 check("R8 lowpower no wake", errN, 1);
    @(negedge clk) wakeFlag = 1'b1;
    #1 check("R8 lowpower wake", errN, 0);

    // R9: output tracks bit on the cycle after the sampling edge
    @(negedge clk) begin flagsIn = 16'h0001; enPin = ~enPin; end
    #1 check("R9 before edge", readoutActive, 0);
    @(posedge clk) #1;
    check("R9 after edge", errN, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule